// File: doc/BRIEF.md
# Synchronous Byte-Lane SRAM with Selectable Read Latency

This block is a single-port synchronous memory. Each rising clock edge samples one command: an address, a chip select and a set of write controls. A write stores a selection of byte lanes. A read returns a whole word. The read word reaches the output in one of two ways, chosen at run time by a mode input. In flow-through mode it comes straight from the array's read register. In pipelined mode it passes through one more output register, so it arrives one cycle later.

An idle or write cycle stops the output drive with the same latency as a read. In pipelined mode this means the word already in flight stays on the output for one more cycle after a deselect (dual-cycle deselect). A global-write input stores every lane, whatever the per-lane controls say. The output enable gates the drive with no clock involved. A sleep input freezes all access while the array keeps its contents. The output carries a drive flag, and the data bus reads zero whenever the flag is low, which stands in for a released tri-state bus.

Top module: `ssram_core`

## Requirements
- R1: While reset is held and after it is released, `rdrive` is 0 and `rdata` is 0 until a read reaches the output.
- R2: With `pipe_mode` = 0, a read sampled at edge k drives the stored word from just after edge k until edge k+1.
- R3: With `pipe_mode` = 1, a read sampled at edge k drives the stored word from just after edge k+1 until edge k+2.
- R4: A cycle with no read command (chip select low, a write, or sleep) stops the drive with the read latency of the current mode. In flow-through mode the drive stops after edge k. In pipelined mode it stops after edge k+1, so the earlier word is still driven for one cycle.
- R5: A lane write is `cs`=1, `wr_qual`=1, `wr_all`=0. Lane i, which is bits [i*LANE_W +: LANE_W], is stored exactly when `lane_en[i]`=1. Other lanes keep their contents, and a write never drives the output.
- R6: When `cs`=1 and `wr_all`=1, every lane is stored, whatever `wr_qual` and `lane_en` are.
- R7: A read is `cs`=1 with `wr_qual`=0 and `wr_all`=0. When `wr_qual` is low, `lane_en` is ignored and changes no memory contents.
- R8: A word written at edge k is returned by a read of the same address sampled at edge k+1.
- R9: `oe` gates `rdrive` combinationally, with no clock edge needed. A read whose output cycle has `oe` low is not driven, but the pipeline still advances.
- R10: While `sleep`=1, no command is sampled and the stored words are kept. The drive is also forced off at once.
- R11: While `rdrive` is 0, `rdata` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset of the pipeline registers |
| pipe_mode | input | 1 | 0 selects flow-through reads, 1 selects pipelined reads |
| cs | input | 1 | Chip select; a command is sampled only when high |
| addr | input | ADDR_W | Word address |
| lane_en | input | DATA_W/LANE_W | Per-lane write enables |
| wr_qual | input | 1 | Qualifier that makes `lane_en` act as a write |
| wr_all | input | 1 | Global write of all lanes |
| wdata | input | DATA_W | Write data |
| oe | input | 1 | Asynchronous output enable |
| sleep | input | 1 | Low-power freeze; blocks all commands |
| rdata | output | DATA_W | Read data; zero when not driven |
| rdrive | output | 1 | High while `rdata` is driven |

## Verification
Results fall due at different times. A flow-through read is due just after its sampling edge, and a pipelined read one edge later. A deselect stops the drive at those same two points. A write is visible to a read on the very next edge. `oe` and `sleep` act on the drive with no edge at all. The bench keeps a cycle-level model with two stage registers. It updates the model at each rising edge from the inputs it drove half a cycle earlier, and compares both outputs at the following falling edge. After changing `oe` alone it compares again within the same cycle, which shows that the gating needs no clock.

// File: rtl/ssr_pkg.sv
package ssr_pkg;

  typedef enum logic [1:0] {
    CMD_IDLE  = 2'd0,
    CMD_READ  = 2'd1,
    CMD_WRITE = 2'd2
  } ssr_cmd_e;

  // Command classification; R7 (read), R5/R6 (write), R10 (sleep blocks all)
  function automatic ssr_cmd_e classify(input logic sel, input logic slp,
                                        input logic qual, input logic all);
    if (!sel || slp)   return CMD_IDLE;
    if (qual || all)   return CMD_WRITE;
    return CMD_READ;
  endfunction

  // A lane is stored when the write is global or the qualified lane enable is set
  function automatic logic lane_hit(input logic wr, input logic all, input logic en);
    return wr && (all || en);
  endfunction

endpackage

// File: rtl/ssr_cmd_decode.sv
module ssr_cmd_decode #(
  parameter int NUM_LANES = 4
) (
  input  logic                 cs,
  input  logic                 sleep,
  input  logic                 wr_qual,
  input  logic                 wr_all,
  input  logic [NUM_LANES-1:0] lane_en,
  output logic                 rd_evt,
  output logic                 wr_evt,
  output logic [NUM_LANES-1:0] lane_we
);
  import ssr_pkg::*;

  ssr_cmd_e cmd;

  always_comb begin
    cmd    = classify(cs, sleep, wr_qual, wr_all);
    rd_evt = (cmd == CMD_READ);
    wr_evt = (cmd == CMD_WRITE);
  end

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    assign lane_we[g] = lane_hit(wr_evt, wr_all, lane_en[g]);
  end

endmodule

// File: rtl/ssr_array.sv
module ssr_array #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 36,
  parameter int LANE_W = 9
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [DATA_W/LANE_W-1:0] lane_we,
  input  logic [DATA_W-1:0]        wdata,
  input  logic                     re,
  output logic [DATA_W-1:0]        rd_q
);
  localparam int NUM_LANES = DATA_W / LANE_W;
  localparam int DEPTH     = 1 << ADDR_W;

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    logic [LANE_W-1:0] lane_mem [DEPTH];
    logic [LANE_W-1:0] lane_rd;

    always_ff @(posedge clk) begin
      if (lane_we[g]) lane_mem[addr] <= wdata[g*LANE_W +: LANE_W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  lane_rd <= '0;
      else if (re) lane_rd <= lane_mem[addr];
    end

    assign rd_q[g*LANE_W +: LANE_W] = lane_rd;
  end

endmodule

// File: rtl/ssr_out_stage.sv
module ssr_out_stage #(
  parameter int DATA_W = 36
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pipe_mode,
  input  logic              oe,
  input  logic              sleep,
  input  logic              rd_evt,
  input  logic [DATA_W-1:0] s1_data,
  output logic              pend,
  output logic [DATA_W-1:0] rdata,
  output logic              rdrive
);
  logic              s1_vld;
  logic              s2_vld;
  logic [DATA_W-1:0] s2_data;
  logic [DATA_W-1:0] src;

  // R4: the deselect flows through the same stages as the read
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_vld  <= 1'b0;
      s2_vld  <= 1'b0;
      s2_data <= '0;
    end else begin
      s1_vld  <= rd_evt;
      s2_vld  <= s1_vld;
      s2_data <= s1_data;
    end
  end

  // R2/R3 mode select, R9/R10 asynchronous gating, R11 zero when released
  always_comb begin
    pend   = pipe_mode ? s2_vld : s1_vld;
    src    = pipe_mode ? s2_data : s1_data;
    rdrive = pend && oe && !sleep;
    rdata  = rdrive ? src : '0;
  end

endmodule

// File: rtl/ssram_core.sv
module ssram_core #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 36,
  parameter int LANE_W = 9
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     pipe_mode,
  input  logic                     cs,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [DATA_W/LANE_W-1:0] lane_en,
  input  logic                     wr_qual,
  input  logic                     wr_all,
  input  logic [DATA_W-1:0]        wdata,
  input  logic                     oe,
  input  logic                     sleep,
  output logic [DATA_W-1:0]        rdata,
  output logic                     rdrive
);
  localparam int NUM_LANES = DATA_W / LANE_W;

  logic                 rd_evt;
  logic                 wr_evt;
  logic [NUM_LANES-1:0] lane_we;
  logic [DATA_W-1:0]    s1_data;
  logic                 pend;

  ssr_cmd_decode #(.NUM_LANES(NUM_LANES)) dec_i (
    .cs(cs), .sleep(sleep), .wr_qual(wr_qual), .wr_all(wr_all),
    .lane_en(lane_en), .rd_evt(rd_evt), .wr_evt(wr_evt), .lane_we(lane_we)
  );

  ssr_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANE_W(LANE_W)) arr_i (
    .clk(clk), .rst_n(rst_n), .addr(addr), .lane_we(lane_we),
    .wdata(wdata), .re(rd_evt), .rd_q(s1_data)
  );

  ssr_out_stage #(.DATA_W(DATA_W)) out_i (
    .clk(clk), .rst_n(rst_n), .pipe_mode(pipe_mode), .oe(oe), .sleep(sleep),
    .rd_evt(rd_evt), .s1_data(s1_data), .pend(pend),
    .rdata(rdata), .rdrive(rdrive)
  );

endmodule

// File: rtl/ssr_chk.sv
module ssr_chk #(
  parameter int DATA_W = 36
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pipe_mode,
  input logic              cs,
  input logic              oe,
  input logic              sleep,
  input logic              rd_evt,
  input logic              wr_evt,
  input logic              pend,
  input logic              rdrive,
  input logic [DATA_W-1:0] rdata
);
  // R2
  flow_read_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_evt |=> (pipe_mode || !oe || sleep || rdrive));

  // R3
  pipe_read_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_evt |=> ##1 (!pipe_mode || !oe || sleep || rdrive));

  // R4
  flow_deselect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_evt |=> (pipe_mode || !rdrive));

  // R4
  dual_deselect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_evt |=> ##1 (!pipe_mode || !rdrive));

  // R9
  oe_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && !oe) |-> !rdrive);

  // R10
  sleep_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep || !cs) |-> !(rd_evt || wr_evt));

  // R11
  release_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rdrive |-> (rdata == '0));

endmodule

bind ssram_core ssr_chk #(.DATA_W(DATA_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .pipe_mode(pipe_mode), .cs(cs), .oe(oe),
  .sleep(sleep), .rd_evt(rd_evt), .wr_evt(wr_evt), .pend(pend),
  .rdrive(rdrive), .rdata(rdata)
);

// File: tb/ssram_core_tb.sv
module ssram_core_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 6;
  localparam int DW = 36;
  localparam int LW = 9;
  localparam int NL = DW / LW;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          pipe_mode = 1'b0;
  logic          cs = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [NL-1:0] lane_en = '0;
  logic          wr_qual = 1'b0;
  logic          wr_all = 1'b0;
  logic [DW-1:0] wdata = '0;
  logic          oe = 1'b1;
  logic          sleep = 1'b0;
  logic [DW-1:0] rdata;
  logic          rdrive;

  always #(CLK_PERIOD/2) clk = ~clk;

  ssram_core #(.ADDR_W(AW), .DATA_W(DW), .LANE_W(LW)) dut_i (
    .clk(clk), .rst_n(rst_n), .pipe_mode(pipe_mode), .cs(cs), .addr(addr),
    .lane_en(lane_en), .wr_qual(wr_qual), .wr_all(wr_all), .wdata(wdata),
    .oe(oe), .sleep(sleep), .rdata(rdata), .rdrive(rdrive)
  );

  int total = 0;
  int bad = 0;

  logic [DW-1:0] ref_mem [DEPTH];
  logic          m1_rd = 1'b0, m2_rd = 1'b0;
  logic [DW-1:0] m1_d = '0, m2_d = '0;

  function automatic logic [DW-1:0] merge_word(input logic [DW-1:0] old_w,
      input logic [DW-1:0] new_w, input logic [NL-1:0] en, input logic all);
    logic [DW-1:0] r;
    r = old_w;
    for (int i = 0; i < NL; i++)
      if (all || en[i]) r[i*LW +: LW] = new_w[i*LW +: LW];
    return r;
  endfunction

  task automatic check(input string tag);
    logic          e_drv;
    logic [DW-1:0] e_dat;
    e_drv = (pipe_mode ? m2_rd : m1_rd) && oe && !sleep;
    e_dat = e_drv ? (pipe_mode ? m2_d : m1_d) : '0;
    total++;
    if (rdrive !== e_drv || rdata !== e_dat) begin
      bad++;
      $display("FAIL %s: drive=%b data=%h expected drive=%b data=%h",
               tag, rdrive, rdata, e_drv, e_dat);
    end
  endtask

  task automatic tick(input string tag);
    @(posedge clk);
    m2_rd = m1_rd;
    m2_d  = m1_d;
    if (cs && !sleep && !wr_qual && !wr_all) begin
      m1_rd = 1'b1;
      m1_d  = ref_mem[addr];
    end else begin
      m1_rd = 1'b0;
      if (cs && !sleep)
        ref_mem[addr] = merge_word(ref_mem[addr], wdata, wr_qual ? lane_en : '0, wr_all);
    end
    @(negedge clk);
    check(tag);
  endtask

  task automatic cmd(input logic c, input logic [AW-1:0] a, input logic [NL-1:0] le,
                     input logic q, input logic al, input logic [DW-1:0] d);
    cs = c; addr = a; lane_en = le; wr_qual = q; wr_all = al; wdata = d;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    total++;
    bad++;
    $display("FAIL watchdog: drive=%b data=%h expected drive=x data=x", rdrive, rdata);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    check("R1");
    rst_n = 1'b1;
    check("R1");

    // preload every word with a global write (R6)
    for (int a = 0; a < DEPTH; a++) begin
      cmd(1'b1, AW'(a), '0, 1'b0, 1'b1, {4'(a), 32'h1234_0000 | 32'(a)});
      tick("R6");
    end

    // flow-through directed cases
    cmd(1'b1, 6'd5, '0, 1'b0, 1'b1, 36'hA_AAAA_AAAA); tick("R6");
    cmd(1'b1, 6'd5, '0, 1'b0, 1'b0, '0);             tick("R8");
    cmd(1'b1, 6'd5, 4'b0101, 1'b1, 1'b0, 36'h5_5555_5555); tick("R4");
    cmd(1'b1, 6'd5, '0, 1'b0, 1'b0, '0);             tick("R5");
    cmd(1'b1, 6'd6, 4'b0000, 1'b1, 1'b1, 36'hC_0FFE_E123); tick("R6");
    cmd(1'b1, 6'd6, '0, 1'b0, 1'b0, '0);             tick("R6");
    cmd(1'b1, 6'd5, 4'b1111, 1'b0, 1'b0, 36'hF_FFFF_FFFF); tick("R7");
    cmd(1'b1, 6'd5, '0, 1'b0, 1'b0, '0);             tick("R7");
    cmd(1'b0, 6'd5, '0, 1'b0, 1'b0, '0);             tick("R2");

    // pipelined latency and dual-cycle deselect
    pipe_mode = 1'b1;
    cmd(1'b1, 6'd6, '0, 1'b0, 1'b0, '0); tick("R3");
    cmd(1'b0, 6'd0, '0, 1'b0, 1'b0, '0); tick("R3");
    tick("R4");
    tick("R4");

    // output enable gating without a clock
    oe = 1'b0;
    cmd(1'b1, 6'd5, '0, 1'b0, 1'b0, '0); tick("R9");
    cmd(1'b0, 6'd0, '0, 1'b0, 1'b0, '0); tick("R9");
    oe = 1'b1;
    #1 check("R9");

    // sleep blocks writes and reads, keeps contents
    sleep = 1'b1;
    #1 check("R10");
    cmd(1'b1, 6'd5, '0, 1'b0, 1'b1, 36'hD_DDDD_DDDD); tick("R10");
    cmd(1'b1, 6'd5, '0, 1'b0, 1'b0, '0);             tick("R10");
    sleep = 1'b0;
    pipe_mode = 1'b0;
    tick("R10");
    cmd(1'b0, 6'd0, '0, 1'b0, 1'b0, '0); tick("R10");

    // constrained random traffic
    for (int n = 0; n < 4000; n++) begin
      if ($urandom_range(0, 49) == 0) pipe_mode = ~pipe_mode;
      oe    = ($urandom_range(0, 9) != 0);
      sleep = ($urandom_range(0, 19) == 0);
      cmd($urandom_range(0, 4) != 0, AW'($urandom), NL'($urandom),
          $urandom_range(0, 3) == 0, $urandom_range(0, 9) == 0,
          {4'($urandom), 32'($urandom)});
      tick("R2 R3 R4 R5 R9 R10 R11");
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule